// File: doc/BRIEF.md
# Indexed GPIO Per-Pin Write Decoder

This block takes 32-bit writes aimed at one index register and turns each into a single-bit update in a banked GPIO register file. The index word carries a global pin number, a register-type code and a small payload. The block splits the pin number into a bank and a pin within that bank, picks the target register or registers from the type code, and changes only the addressed bit. The one exception is command-source registers, which are selected per group of eight pins. Each type has its own rule: masking by the bank's input or output capability, write-one-to-clear with a pending-interrupt count, or a group-based bit position.

Each bank has 32 pins. The registers are data, direction, interrupt enable, three sensitivity selects, interrupt status, two debounce selects, reset tolerance, input mask and two command-source words. Interrupt status bits are set by a per-pin event input from outside the block. A counter tracks how many status bits are set. A strobe tells downstream interrupt evaluation to run again, and an error pulse marks malformed index words.

Top module: `gpidx_wr_decoder`

## Requirements
- R1: A write takes effect only when `wr_valid_i` is high and `wr_addr_i[11:2]` equals the index register's word address (byte offset 0x2AC). Any other write changes no state and raises neither strobe nor error.
- R2: The index word's bits 7:0 are the global pin, bits 19:16 the type code and bits 24:20 the payload. Bank = pin / 32, pin-in-bank = pin % 32, group = pin-in-bank / 8.
- R3: Type 0 (data) places payload bit 20 at the pin in the bank's data word, then ANDs the whole word with the bank's output-capability mask.
- R4: Type 1 (direction) places bit 20 at the pin, then stores (word OR NOT input_cap) AND output_cap for the whole bank.
- R5: Type 2 (interrupt) places bit 20 in enable and bits 21, 22 and 23 in sensitivity 0, 1 and 2 at the pin, with no masking.
- R6: In a type 2 write, bit 24 = 1 clears the pin's status bit (write-one-to-clear) and bit 24 = 0 leaves it unchanged. An `evt_i` bit sets its status bit, and a set wins over a clear of the same pin in the same cycle.
- R7: `pending_o` rises by the number of status bits newly set in a cycle and falls by one when a set status bit is cleared. Clearing a bit that is already clear leaves it unchanged, and it never underflows.
- R8: Type 3 places bit 20 in debounce select 1 and bit 21 in debounce select 2 at the pin. Type 4 places bit 20 in reset tolerance at the pin.
- R9: Type 5 places bit 20 in command source 0 and bit 21 in command source 1 at bit position 8 × group, then ANDs the result with the command-source mask (default 0x01010101).
- R10: Type 6 places bit 20 in the input mask at the pin, then ANDs the result with the bank's input-capability mask.
- R11: A nonzero command bit (bit 12) makes `err_o` high for one cycle after the write, and the write is still applied.
- R12: A type code of 7 or above, or a bank at or beyond NUM_BANKS, makes `err_o` high for one cycle, changes no state and gives no strobe.
- R13: `upd_o` pulses for one cycle, with `upd_bank_o` set to the bank, after each accepted write of type data, direction, interrupt or input mask. Types 3, 4 and 5 give no strobe.
- R14: A synchronous active-high reset clears every register, `pending_o`, `err_o` and `upd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Write valid |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | 32 | Index word |
| evt_i | input | NUM_BANKS*32 | Per-pin interrupt event, sets status |
| data_o | output | NUM_BANKS*32 | Data words |
| dir_o | output | NUM_BANKS*32 | Direction words |
| int_en_o | output | NUM_BANKS*32 | Interrupt enables |
| sens0_o | output | NUM_BANKS*32 | Sensitivity select 0 |
| sens1_o | output | NUM_BANKS*32 | Sensitivity select 1 |
| sens2_o | output | NUM_BANKS*32 | Sensitivity select 2 |
| status_o | output | NUM_BANKS*32 | Interrupt status |
| deb1_o | output | NUM_BANKS*32 | Debounce select 1 |
| deb2_o | output | NUM_BANKS*32 | Debounce select 2 |
| rst_tol_o | output | NUM_BANKS*32 | Reset tolerance |
| in_mask_o | output | NUM_BANKS*32 | Input mask |
| cmd_src0_o | output | NUM_BANKS*32 | Command source 0 |
| cmd_src1_o | output | NUM_BANKS*32 | Command source 1 |
| pending_o | output | CNT_W | Count of set status bits |
| err_o | output | 1 | Error pulse |
| upd_o | output | 1 | Re-evaluation strobe |
| upd_bank_o | output | 3 | Bank of the last strobe |

## Verification
Interrupt events and write-one-to-clear writes can act on the status word and the pending count in the same cycle. The bench drives `evt_i` in the same cycle as a clearing write in two cases. In the first, the event hits a pin that is already set and a new pin while a different pin is cleared. In the second, the event and the clear hit the same pin. Both the status word and `pending_o` are compared against the net change that R6 and R7 define. A final event in a second bank then shows that counts from separate banks add.

// File: rtl/gpidx_pkg.sv
package gpidx_pkg;
  localparam int WORD_W   = 32;
  localparam int PIN_W    = 8;
  localparam int LPIN_W   = 5;
  localparam int GRP_W    = 2;
  localparam int BANKID_W = PIN_W - LPIN_W;
  localparam int TYPE_LO  = 16;
  localparam int CMD_BIT  = 12;
  localparam int PAY_LO   = 20;
  localparam int PAY_W    = 5;

  typedef enum logic [3:0] {
    T_DATA  = 4'd0,
    T_DIR   = 4'd1,
    T_INT   = 4'd2,
    T_DEB   = 4'd3,
    T_TOL   = 4'd4,
    T_CSRC  = 4'd5,
    T_IMASK = 4'd6
  } gpidx_type_e;

  typedef struct packed {
    logic [BANKID_W-1:0] bank;
    logic [LPIN_W-1:0]   lpin;
    logic [GRP_W-1:0]    grp;
    logic [3:0]          typ;
    logic [PAY_W-1:0]    pay;
  } gpidx_cmd_t;
endpackage

// File: rtl/gpidx_decode.sv
module gpidx_decode
  import gpidx_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_BANKS  = 2,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 12'h2AC
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              hit_o,
  output logic              bad_o,
  output logic              cmd_err_o,
  output gpidx_cmd_t        cmd_o
);
  logic [PIN_W-1:0] pin;
  logic unused_bits;

  assign hit_o = valid_i && (addr_i[ADDR_W-1:2] == INDEX_ADDR[ADDR_W-1:2]);
  assign pin   = data_i[PIN_W-1:0];

  always_comb begin
    cmd_o.bank = pin[PIN_W-1:LPIN_W];
    cmd_o.lpin = pin[LPIN_W-1:0];
    cmd_o.grp  = pin[LPIN_W-1:LPIN_W-GRP_W];
    cmd_o.typ  = data_i[TYPE_LO+3:TYPE_LO];
    cmd_o.pay  = data_i[PAY_LO+PAY_W-1:PAY_LO];
  end

  assign bad_o     = (data_i[TYPE_LO+3:TYPE_LO] > 4'd6) ||
                     (int'(pin[PIN_W-1:LPIN_W]) >= NUM_BANKS);
  assign cmd_err_o = data_i[CMD_BIT];
  assign unused_bits = ^{addr_i[1:0], data_i[WORD_W-1:PAY_LO+PAY_W],
                         data_i[TYPE_LO-1:CMD_BIT+1], data_i[CMD_BIT-1:PIN_W]};
endmodule

// File: rtl/gpidx_bank.sv
module gpidx_bank
  import gpidx_pkg::*;
#(
  parameter logic [31:0] IN_CAP    = 32'hFFFF_FFFF,
  parameter logic [31:0] OUT_CAP   = 32'hFFFF_FFFF,
  parameter logic [31:0] CSRC_MASK = 32'h0101_0101
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we_i,
  input  gpidx_cmd_t  cmd_i,
  input  logic [31:0] evt_i,
  output logic [31:0] data_q,
  output logic [31:0] dir_q,
  output logic [31:0] inten_q,
  output logic [31:0] sens0_q,
  output logic [31:0] sens1_q,
  output logic [31:0] sens2_q,
  output logic [31:0] status_q,
  output logic [31:0] deb1_q,
  output logic [31:0] deb2_q,
  output logic [31:0] tol_q,
  output logic [31:0] imask_q,
  output logic [31:0] cs0_q,
  output logic [31:0] cs1_q,
  output logic        cleared_o,
  output logic [5:0]  added_o
);
  logic [31:0] oh, cs_oh, st_clr, st_kept, st_next, dir_dep;

  function automatic logic [31:0] dep(input logic [31:0] w, input logic [31:0] sel, input logic b);
    return (w & ~sel) | (b ? sel : 32'h0);
  endfunction

  always_comb begin
    oh      = 32'h1 << cmd_i.lpin;
    cs_oh   = 32'h1 << {cmd_i.grp, 3'b000};
    st_clr  = (we_i && cmd_i.typ == T_INT && cmd_i.pay[4]) ? oh : 32'h0;
    st_kept = status_q & ~st_clr;
    st_next = st_kept | evt_i;
    dir_dep = dep(dir_q, oh, cmd_i.pay[0]);
  end

  assign cleared_o = |(status_q & st_clr);
  assign added_o   = 6'($countones(evt_i & ~st_kept));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0; dir_q <= '0; inten_q <= '0; sens0_q <= '0;
      sens1_q <= '0; sens2_q <= '0; status_q <= '0; deb1_q <= '0;
      deb2_q <= '0; tol_q <= '0; imask_q <= '0; cs0_q <= '0; cs1_q <= '0;
    end else begin
      status_q <= st_next;
      if (we_i) begin
        case (cmd_i.typ)
          T_DATA:  data_q <= dep(data_q, oh, cmd_i.pay[0]) & OUT_CAP;
          T_DIR:   dir_q  <= (dir_dep | ~IN_CAP) & OUT_CAP;
          T_INT: begin
            inten_q <= dep(inten_q, oh, cmd_i.pay[0]);
            sens0_q <= dep(sens0_q, oh, cmd_i.pay[1]);
            sens1_q <= dep(sens1_q, oh, cmd_i.pay[2]);
            sens2_q <= dep(sens2_q, oh, cmd_i.pay[3]);
          end
          T_DEB: begin
            deb1_q <= dep(deb1_q, oh, cmd_i.pay[0]);
            deb2_q <= dep(deb2_q, oh, cmd_i.pay[1]);
          end
          T_TOL:   tol_q <= dep(tol_q, oh, cmd_i.pay[0]);
          T_CSRC: begin
            cs0_q <= dep(cs0_q, cs_oh, cmd_i.pay[0]) & CSRC_MASK;
            cs1_q <= dep(cs1_q, cs_oh, cmd_i.pay[1]) & CSRC_MASK;
          end
          T_IMASK: imask_q <= dep(imask_q, oh, cmd_i.pay[0]) & IN_CAP;
          default: ;
        endcase
      end
    end
  end

  // R6: a clear without a same-pin event leaves that status bit low
  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    (we_i && cmd_i.typ == T_INT && cmd_i.pay[4] && !evt_i[cmd_i.lpin])
      |=> !status_q[$past(cmd_i.lpin)]);
  // R6: an event always leaves its status bit set
  p_evt_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_i != 32'h0) |=> (($past(evt_i) & ~status_q) == 32'h0));
endmodule

// File: rtl/gpidx_pend.sv
module gpidx_pend #(
  parameter int NUM_BANKS = 2,
  parameter int CNT_W     = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_BANKS-1:0]      cleared_i,
  input  logic [NUM_BANKS-1:0][5:0] added_i,
  output logic [CNT_W-1:0]          pend_q
);
  logic [CNT_W:0] up_sum, dn_sum, grown;

  always_comb begin
    up_sum = '0;
    dn_sum = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      up_sum = up_sum + (CNT_W+1)'(added_i[b]);
      dn_sum = dn_sum + (CNT_W+1)'(cleared_i[b]);
    end
    grown = (CNT_W+1)'(pend_q) + up_sum;
  end

  always_ff @(posedge clk) begin
    if (rst)                  pend_q <= '0;
    else if (grown >= dn_sum) pend_q <= CNT_W'(grown - dn_sum);
    else                      pend_q <= '0;
  end

  // R7: with no new events the count never grows, and zero stays zero
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0 && up_sum == '0) |=> (pend_q == '0));
  p_no_growth_r7: assert property (@(posedge clk) disable iff (rst)
    (up_sum == '0) |=> (pend_q <= $past(pend_q)));
endmodule

// File: rtl/gpidx_wr_decoder.sv
module gpidx_wr_decoder
  import gpidx_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 2,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 12'h2AC,
  parameter logic [NUM_BANKS*32-1:0] IN_CAP  = {32'hFFFF_FFFF, 32'h0000_FFFF},
  parameter logic [NUM_BANKS*32-1:0] OUT_CAP = {32'hFFFF_FFFF, 32'h00FF_00FF},
  parameter logic [31:0] CSRC_MASK = 32'h0101_0101,
  localparam int NPINS = NUM_BANKS * 32,
  localparam int CNT_W = $clog2(NPINS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [31:0]         wr_data_i,
  input  logic [NPINS-1:0]    evt_i,
  output logic [NPINS-1:0]    data_o,
  output logic [NPINS-1:0]    dir_o,
  output logic [NPINS-1:0]    int_en_o,
  output logic [NPINS-1:0]    sens0_o,
  output logic [NPINS-1:0]    sens1_o,
  output logic [NPINS-1:0]    sens2_o,
  output logic [NPINS-1:0]    status_o,
  output logic [NPINS-1:0]    deb1_o,
  output logic [NPINS-1:0]    deb2_o,
  output logic [NPINS-1:0]    rst_tol_o,
  output logic [NPINS-1:0]    in_mask_o,
  output logic [NPINS-1:0]    cmd_src0_o,
  output logic [NPINS-1:0]    cmd_src1_o,
  output logic [CNT_W-1:0]    pending_o,
  output logic                err_o,
  output logic                upd_o,
  output logic [BANKID_W-1:0] upd_bank_o
);
  logic       d_hit, d_bad, d_cmd_err, accept, strobe_type;
  gpidx_cmd_t d_cmd;
  logic [NUM_BANKS-1:0]      bank_clr;
  logic [NUM_BANKS-1:0][5:0] bank_add;

  gpidx_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .INDEX_ADDR(INDEX_ADDR)) u_dec (
    .valid_i(wr_valid_i), .addr_i(wr_addr_i), .data_i(wr_data_i),
    .hit_o(d_hit), .bad_o(d_bad), .cmd_err_o(d_cmd_err), .cmd_o(d_cmd)
  );

  assign accept      = d_hit && !d_bad;
  assign strobe_type = (d_cmd.typ == T_DATA) || (d_cmd.typ == T_DIR) ||
                       (d_cmd.typ == T_INT)  || (d_cmd.typ == T_IMASK);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpidx_bank #(
      .IN_CAP(IN_CAP[b*32 +: 32]), .OUT_CAP(OUT_CAP[b*32 +: 32]), .CSRC_MASK(CSRC_MASK)
    ) u_bank (
      .clk(clk), .rst(rst),
      .we_i(accept && (int'(d_cmd.bank) == b)),
      .cmd_i(d_cmd), .evt_i(evt_i[b*32 +: 32]),
      .data_q(data_o[b*32 +: 32]), .dir_q(dir_o[b*32 +: 32]),
      .inten_q(int_en_o[b*32 +: 32]), .sens0_q(sens0_o[b*32 +: 32]),
      .sens1_q(sens1_o[b*32 +: 32]), .sens2_q(sens2_o[b*32 +: 32]),
      .status_q(status_o[b*32 +: 32]), .deb1_q(deb1_o[b*32 +: 32]),
      .deb2_q(deb2_o[b*32 +: 32]), .tol_q(rst_tol_o[b*32 +: 32]),
      .imask_q(in_mask_o[b*32 +: 32]), .cs0_q(cmd_src0_o[b*32 +: 32]),
      .cs1_q(cmd_src1_o[b*32 +: 32]),
      .cleared_o(bank_clr[b]), .added_o(bank_add[b])
    );
  end

  gpidx_pend #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_pend (
    .clk(clk), .rst(rst), .cleared_i(bank_clr), .added_i(bank_add), .pend_q(pending_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o      <= 1'b0;
      upd_o      <= 1'b0;
      upd_bank_o <= '0;
    end else begin
      err_o <= d_hit && (d_bad || d_cmd_err);
      upd_o <= accept && strobe_type;
      if (accept && strobe_type) upd_bank_o <= d_cmd.bank;
    end
  end

  // R1: writes that miss the index register leave no strobe and no error
  p_ignore_r1: assert property (@(posedge clk) disable iff (rst)
    !d_hit |=> (!upd_o && !err_o));
  // R11: a set command bit is always reported
  p_cmd_err_r11: assert property (@(posedge clk) disable iff (rst)
    (d_hit && d_cmd_err) |=> err_o);
  // R12: a rejected write changes no bank state except event-driven status
  p_reject_r12: assert property (@(posedge clk) disable iff (rst)
    (d_hit && d_bad) |=> (err_o && !upd_o && $stable(data_o) && $stable(dir_o) &&
      $stable(int_en_o) && $stable(in_mask_o) && $stable(rst_tol_o) && $stable(cmd_src0_o)));
  // R13: the strobe only follows an accepted write
  p_upd_src_r13: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> $past(accept));
endmodule

// File: tb/gpidx_wr_decoder_tb.sv
`timescale 1ns/1ps
module gpidx_wr_decoder_tb;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid_i = 1'b0;
  logic [11:0]   wr_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic [NP-1:0] evt_i = '0;
  logic [NP-1:0] data_o, dir_o, int_en_o, sens0_o, sens1_o, sens2_o, status_o;
  logic [NP-1:0] deb1_o, deb2_o, rst_tol_o, in_mask_o, cmd_src0_o, cmd_src1_o;
  logic [6:0]    pending_o;
  logic          err_o, upd_o;
  logic [2:0]    upd_bank_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpidx_wr_decoder u_dut (
    .clk(clk), .rst(rst), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .evt_i(evt_i), .data_o(data_o), .dir_o(dir_o),
    .int_en_o(int_en_o), .sens0_o(sens0_o), .sens1_o(sens1_o), .sens2_o(sens2_o),
    .status_o(status_o), .deb1_o(deb1_o), .deb2_o(deb2_o), .rst_tol_o(rst_tol_o),
    .in_mask_o(in_mask_o), .cmd_src0_o(cmd_src0_o), .cmd_src1_o(cmd_src1_o),
    .pending_o(pending_o), .err_o(err_o), .upd_o(upd_o), .upd_bank_o(upd_bank_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic v, input logic [11:0] a, input logic [31:0] d, input logic [NP-1:0] e);
    @(negedge clk);
    wr_valid_i = v; wr_addr_i = a; wr_data_i = d; evt_i = e;
    @(negedge clk);
    wr_valid_i = 1'b0; evt_i = '0;
  endtask

  function automatic logic [31:0] pick(input logic [3:0] sel, input int bk);
    case (sel)
      4'd0: return data_o[bk*32 +: 32];
      4'd1: return dir_o[bk*32 +: 32];
      4'd2: return int_en_o[bk*32 +: 32];
      4'd3: return sens1_o[bk*32 +: 32];
      4'd4: return deb2_o[bk*32 +: 32];
      4'd5: return rst_tol_o[bk*32 +: 32];
      4'd6: return cmd_src0_o[bk*32 +: 32];
      default: return in_mask_o[bk*32 +: 32];
    endcase
  endfunction

  // {bank, selector, index word, expected word}; applied in order from reset
  localparam logic [68:0] VEC [12] = '{
    {1'b0, 4'd0, 32'h0010_0003, 32'h0000_0008},  // R3 data pin 3
    {1'b0, 4'd0, 32'h0010_000A, 32'h0000_0008},  // R3 input-only pin masked off
    {1'b1, 4'd0, 32'h0010_0028, 32'h0000_0100},  // R2 pin 40 -> bank 1 pin 8
    {1'b0, 4'd1, 32'h0011_0003, 32'h00FF_0008},  // R4 direction set
    {1'b0, 4'd1, 32'h0001_0003, 32'h00FF_0000},  // R4 direction clear
    {1'b0, 4'd3, 32'h0052_0005, 32'h0000_0020},  // R5 sens1 pin 5
    {1'b0, 4'd2, 32'h0052_0006, 32'h0000_0060},  // R5 enable pin 6
    {1'b1, 4'd4, 32'h0023_0021, 32'h0000_0002},  // R8 debounce 2 pin 33
    {1'b1, 4'd5, 32'h0014_003F, 32'h8000_0000},  // R8 tolerance pin 63
    {1'b0, 4'd6, 32'h0035_0014, 32'h0001_0000},  // R9 group 2 -> bit 16
    {1'b0, 4'd7, 32'h0016_0014, 32'h0000_0000},  // R10 output-only pin masked
    {1'b0, 4'd7, 32'h0016_0009, 32'h0000_0200}   // R10 input-capable pin
  };

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R14 reset state
    check("R14 data", data_o[31:0], 32'h0);
    check("R14 pending", {25'h0, pending_o}, 32'h0);
    check("R14 err/upd", {30'h0, err_o, upd_o}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      wr(1'b1, 12'h2AC, VEC[i][63:32], '0);
      check($sformatf("vector %0d (R2-R10)", i), pick(VEC[i][67:64], int'(VEC[i][68])), VEC[i][31:0]);
    end
    check("R9 cmd source 1", cmd_src1_o[31:0], 32'h0001_0000);
    check("R5 sens2 untouched", sens2_o[31:0], 32'h0);

    // R13 strobe after data write, one cycle only
    wr(1'b1, 12'h2AC, 32'h0010_0004, '0);
    check("R13 strobe", {31'h0, upd_o}, 32'h1);
    check("R13 strobe bank", {29'h0, upd_bank_o}, 32'h0);
    check("R3 data pin 4", data_o[31:0], 32'h18);
    @(negedge clk);
    check("R13 strobe width", {31'h0, upd_o}, 32'h0);
    // R13 no strobe for tolerance
    wr(1'b1, 12'h2AC, 32'h0014_0000, '0);
    check("R13 no strobe tol", {31'h0, upd_o}, 32'h0);
    check("R8 tolerance pin 0", rst_tol_o[31:0], 32'h1);
    // R11 command bit: error, write still applied
    wr(1'b1, 12'h2AC, 32'h0010_1005, '0);
    check("R11 err", {31'h0, err_o}, 32'h1);
    check("R11 write applied", data_o[31:0], 32'h38);
    // R1 wrong address and no valid
    wr(1'b1, 12'h2A8, 32'h0010_0006, '0);
    check("R1 wrong addr", data_o[31:0], 32'h38);
    check("R1 no err/upd", {30'h0, err_o, upd_o}, 32'h0);
    wr(1'b0, 12'h2AC, 32'h0010_0006, '0);
    check("R1 not valid", data_o[31:0], 32'h38);
    // R12 reserved type and bank out of range
    wr(1'b1, 12'h2AC, 32'h0017_0006, '0);
    check("R12 reserved err", {30'h0, err_o, upd_o}, 32'h2);
    check("R12 reserved no change", data_o[31:0], 32'h38);
    wr(1'b1, 12'h2AC, 32'h0010_0046, '0);
    check("R12 bank range err", {31'h0, err_o}, 32'h1);
    check("R12 bank range no change", data_o[63:32], 32'h100);

    // R6 / R7 events and clears
    wr(1'b0, 12'h0, 32'h0, 64'h7);
    check("R6 events set", status_o[31:0], 32'h7);
    check("R7 pending up", {25'h0, pending_o}, 32'd3);
    wr(1'b1, 12'h2AC, 32'h0102_0001, '0);
    check("R6 w1c", status_o[31:0], 32'h5);
    check("R7 pending down", {25'h0, pending_o}, 32'd2);
    wr(1'b1, 12'h2AC, 32'h0102_0001, '0);
    check("R7 clear of clear bit", {25'h0, pending_o}, 32'd2);
    wr(1'b1, 12'h2AC, 32'h0002_0002, '0);
    check("R6 b24=0 keeps status", status_o[31:0], 32'h5);
    // same cycle: events on pins 2 (set) and 10 (new) while clearing pin 0
    wr(1'b1, 12'h2AC, 32'h0102_0000, 64'h404);
    check("R6 concurrent status", status_o[31:0], 32'h404);
    check("R7 concurrent pending", {25'h0, pending_o}, 32'd2);
    // same pin event and clear: set wins
    wr(1'b1, 12'h2AC, 32'h0102_0002, 64'h4);
    check("R6 set wins", status_o[31:0], 32'h404);
    check("R7 set wins pending", {25'h0, pending_o}, 32'd2);
    wr(1'b0, 12'h0, 32'h0, 64'h8000_0000_0000_0000);
    check("R7 bank1 event", {25'h0, pending_o}, 32'd3);
    wr(1'b1, 12'h2AC, 32'h0102_003F, '0);
    check("R6 bank1 clear", status_o[63:32], 32'h0);
    check("R7 bank1 clear", {25'h0, pending_o}, 32'd2);

    // R14 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R14 reset pending", {25'h0, pending_o}, 32'h0);
    check("R14 reset data", data_o[31:0], 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule